// File: doc/BRIEF.md
# Power-Fail Guarded Register Bus Interface

This block is a clocked front end for an asynchronous, SRAM-style byte port with a 15-bit address. It sits in front of a battery-backed register file and turns the chip-select, output-enable and write-enable strobes into register reads and single-cycle register writes. All bus inputs and supply flags are sampled through two-flop synchronisers. Edges and cycle boundaries are then decided on the synchronised copies.

Three digital comparator flags describe the supply: a low-supply protect flag, a battery-backup flag and a supply-good flag. While either of the first two is set, the port is locked. No read drives the bus, and no write reaches the register file. Any write that is in flight is dropped. Once both flags clear and supply-good is high, the port stays locked for a hold-off count of `HOLD_CYC` clock cycles, which defaults to 200 ms at 50 MHz. A dip during the count starts it again. After reset, the port also begins in the hold-off.

The register file is outside the block. It is reached through a combinational read address and data pair and a one-cycle write strobe with address and data.

Top module: `pf_reg_port`

## Requirements
- R1: With chip-select low, output-enable low and write-enable high (all active low), and the port unlocked, `data_oe_o` is 1 and `data_o` equals `rd_data_i` for `rd_addr_o` = the bus address. Otherwise `data_oe_o` is 0 and `data_o` is 0.
- R2: A write cycle is open only while chip-select and write-enable are both low. It opens when the later of the two strobes falls, in whichever order they fall.
- R3: A write commits when the first of chip-select or write-enable rises. Exactly one `wr_en_o` pulse of one cycle is produced, carrying the address and data held in the last cycle of the open write.
- R4: If the address changes while a write is open, the write is aborted and nothing is committed.
- R5: While the protect flag is high, no read drives the bus and no write commits, and a write that is open when the flag rises is discarded.
- R6: After the protect and battery flags clear, access stays locked until supply-good has been high for `HOLD_CYC` consecutive cycles. A dip restarts the count, and the same hold-off applies after reset.
- R7: While the battery-backup flag is high, no write commits and no read drives the bus.
- R8: Write-enable low overrides output-enable: the bus is never driven while a write is open.
- R9: A new write can open only after a synchronised cycle in which the port is idle. Strobes held low across protection or across the end of a previous cycle start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable, active low, asynchronous |
| we_n_i | input | 1 | Write-enable, active low, asynchronous |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| data_o | output | DATA_W | Bus read data, 0 when not driven |
| data_oe_o | output | 1 | Bus output drive enable |
| prot_i | input | 1 | Low-supply protect flag |
| batt_i | input | 1 | Battery-backup flag |
| pgood_i | input | 1 | Supply-good flag |
| rd_addr_o | output | ADDR_W | Register file read address |
| rd_data_i | input | DATA_W | Register file read data |
| wr_en_o | output | 1 | Register file write strobe |
| wr_addr_o | output | ADDR_W | Register file write address |
| wr_data_o | output | DATA_W | Register file write data |

## Verification
A write ending and a supply lock can fall in the same cycle. Likewise, a strobe edge can meet the moment the hold-off expires. The bench provokes the first case by raising the protect flag while a write is open and only then releasing write-enable. It judges the result by the count of write strobes and by reading the target address back after recovery. It provokes the second case by holding both strobes low through the whole hold-off. It then checks that no write strobe follows when the lock lifts, and that none follows when write-enable rises.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } ctl_t;

  typedef struct packed {
    logic prot;
    logic batt;
    logic pgood;
  } pwr_t;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pf_guard.sv
module pf_guard #(
  parameter int HOLD_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prot_i,
  input  logic batt_i,
  input  logic pgood_i,
  output logic block_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic             low;

  assign low = prot_i | batt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      cnt_q    <= '0;
    end else if (low) begin
      locked_q <= 1'b1;
      cnt_q    <= '0;
    end else if (locked_q) begin
      if (!pgood_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
        locked_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign block_o = locked_q | low;

  // R6
  holdoff_pgood_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(pgood_i) && !$past(low));
  // R6
  holdoff_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(HOLD_CYC));
  // R5
  lock_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low |=> locked_q);
endmodule

// File: rtl/pf_cycle.sv
module pf_cycle #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              block_i,
  output logic              rd_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              in_wr_q, idle_seen_q, wr_act, idle, start;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  assign wr_act = !cs_n_i && !we_n_i;
  assign idle   = cs_n_i || (we_n_i && oe_n_i);
  assign start  = !in_wr_q && wr_act && !block_i && idle_seen_q;
  assign rd_o   = !cs_n_i && !oe_n_i && we_n_i && !block_i && !in_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_wr_q     <= 1'b0;
      idle_seen_q <= 1'b0;
      wa_q        <= '0;
      wd_q        <= '0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_en_o     <= 1'b0;
      idle_seen_q <= !block_i && !start && !in_wr_q && (idle_seen_q || idle);
      if (start) begin
        in_wr_q <= 1'b1;
        wa_q    <= addr_i;
        wd_q    <= data_i;
      end else if (in_wr_q) begin
        if (block_i) begin
          in_wr_q <= 1'b0;                 // discarded by protection
        end else if (!wr_act) begin
          in_wr_q   <= 1'b0;               // earlier rising strobe commits
          wr_en_o   <= 1'b1;
          wr_addr_o <= wa_q;
          wr_data_o <= wd_q;
        end else if (addr_i != wa_q) begin
          in_wr_q <= 1'b0;                 // address moved: abort
        end else begin
          wd_q <= data_i;
        end
      end
    end
  end

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R3
  commit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(in_wr_q) && !in_wr_q);
  // R5
  protect_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wr_q && block_i) |=> !wr_en_o);
  // R4
  addr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wr_q && wr_act && !block_i && addr_i != wa_q) |=> !wr_en_o && !in_wr_q);
  // R8
  no_drive_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wr_q || wr_act) |-> !rd_o);
  // R9
  start_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_wr_q) |-> $past(idle_seen_q));
endmodule

// File: rtl/pf_reg_port.sv
module pf_reg_port #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int HOLD_MS  = 200,
  parameter int HOLD_CYC = CLK_HZ / 1000 * HOLD_MS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              prot_i,
  input  logic              batt_i,
  input  logic              pgood_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import pf_pkg::*;

  localparam int BUS_W = ADDR_W + DATA_W;

  ctl_t              ctl_raw, ctl_s;
  pwr_t              pwr_raw, pwr_s;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdat_s;
  logic              block, rd;

  assign ctl_raw = '{cs_n: cs_n_i, oe_n: oe_n_i, we_n: we_n_i};
  assign pwr_raw = '{prot: prot_i, batt: batt_i, pgood: pgood_i};

  pf_sync #(.W($bits(ctl_t)), .RST('1)) u_ctl_sync (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_s));
  pf_sync #(.W($bits(pwr_t)), .RST(3'b110)) u_pwr_sync (
    .clk_i, .rst_ni, .d_i(pwr_raw), .q_o(pwr_s));
  pf_sync #(.W(BUS_W), .RST('0)) u_bus_sync (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o(bus_s));

  assign {addr_s, wdat_s} = bus_s;

  pf_guard #(.HOLD_CYC(HOLD_CYC)) u_guard (
    .clk_i, .rst_ni,
    .prot_i(pwr_s.prot), .batt_i(pwr_s.batt), .pgood_i(pwr_s.pgood),
    .block_o(block));

  pf_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cycle (
    .clk_i, .rst_ni,
    .cs_n_i(ctl_s.cs_n), .oe_n_i(ctl_s.oe_n), .we_n_i(ctl_s.we_n),
    .addr_i(addr_s), .data_i(wdat_s), .block_i(block),
    .rd_o(rd), .wr_en_o, .wr_addr_o, .wr_data_o);

  assign rd_addr_o = addr_s;
  assign data_oe_o = rd;
  assign data_o    = rd ? rd_data_i : '0;

  // R7
  batt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_s.batt && $past(pwr_s.batt)) |-> !wr_en_o && !data_oe_o);
  // R5
  prot_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_s.prot |-> !data_oe_o);
endmodule

// File: tb/sim_pf_reg_port.sv
module sim_pf_reg_port;
  localparam int AW = 15, DW = 8, HOLD = 40;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, oe_n = 1, we_n = 1, prot = 0, batt = 0, pgood = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic doe, wr_en;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int checks = 0, errors = 0, wr_cnt = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pf_reg_port #(.ADDR_W(AW), .DATA_W(DW), .HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .prot_i(prot), .batt_i(batt), .pgood_i(pgood),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic oe_exp,
                          input logic [DW-1:0] d_exp);
    addr = a; cs_n = 0; oe_n = 0; we_n = 1;
    wait_n(4);
    chk(req, {31'd0, doe}, {31'd0, oe_exp});
    chk(req, {24'd0, dout}, oe_exp ? {24'd0, d_exp} : 32'd0);
    cs_n = 1; oe_n = 1;
    wait_n(3);
  endtask

  // fall_we_first: which strobe falls first; rise_we_first: which rises first
  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit fall_we_first, input bit rise_we_first);
    addr = a; din = d; oe_n = 1;
    wait_n(2);
    if (fall_we_first) we_n = 0; else cs_n = 0;
    wait_n(3);
    if (fall_we_first) cs_n = 0; else we_n = 0;
    wait_n(5);
    if (rise_we_first) we_n = 1; else cs_n = 1;
    wait_n(3);
    cs_n = 1; we_n = 1;
    wait_n(4);
  endtask

  task automatic t_reset;
    int c0;
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
    mem[15'h0123] = 8'h5A;
    wait_n(3); rst_n = 1;
    c0 = wr_cnt;
    // R6 hold-off after reset: read stays undriven
    read_chk("R6 reset lock", 15'h0123, 1'b0, 8'h00);
    chk("R6 reset no write", wr_cnt, c0);
    wait_n(HOLD + 5);
    read_chk("R1 read after reset", 15'h0123, 1'b1, 8'h5A);
  endtask

  task automatic t_write_orders;
    int c0 = wr_cnt;
    write(15'h0010, 8'hA1, 0, 1);   // R2 cs first falls, R3 we rises first
    chk("R3 one strobe", wr_cnt, c0 + 1);
    read_chk("R3 data cs-fall/we-rise", 15'h0010, 1'b1, 8'hA1);
    write(15'h7FFF, 8'h3C, 1, 0);   // R2 we falls first, R3 cs rises first
    chk("R3 one strobe", wr_cnt, c0 + 2);
    read_chk("R2 data we-fall/cs-rise", 15'h7FFF, 1'b1, 8'h3C);
    read_chk("R1 untouched addr", 15'h0011, 1'b1, 8'h00);
  endtask

  task automatic t_addr_abort;
    int c0 = wr_cnt;
    addr = 15'h0200; din = 8'h77;
    wait_n(2);
    cs_n = 0; we_n = 0;
    wait_n(5);
    addr = 15'h0201;
    wait_n(5);
    we_n = 1; cs_n = 1;
    wait_n(4);
    chk("R4 abort no strobe", wr_cnt, c0);
    read_chk("R4 old addr kept", 15'h0200, 1'b1, 8'h00);
    read_chk("R4 new addr kept", 15'h0201, 1'b1, 8'h00);
  endtask

  task automatic t_we_overrides;
    addr = 15'h0300; din = 8'hE4;
    wait_n(2);
    cs_n = 0; oe_n = 0; we_n = 0;
    wait_n(5);
    chk("R8 no drive in write", {31'd0, doe}, 32'd0);
    we_n = 1; cs_n = 1; oe_n = 1;
    wait_n(4);
    read_chk("R8 write with oe low lands", 15'h0300, 1'b1, 8'hE4);
  endtask

  task automatic t_prot_discard;
    int c0 = wr_cnt;
    addr = 15'h0400; din = 8'h99;
    wait_n(2);
    cs_n = 0; we_n = 0;
    wait_n(5);
    prot = 1;
    wait_n(4);
    we_n = 1; cs_n = 1;
    wait_n(4);
    chk("R5 in-flight discarded", wr_cnt, c0);
    read_chk("R5 read locked", 15'h0010, 1'b0, 8'h00);
    write(15'h0401, 8'h11, 0, 0);
    chk("R5 write locked", wr_cnt, c0);
    prot = 0;
    wait_n(HOLD / 2);
    read_chk("R6 still in hold-off", 15'h0010, 1'b0, 8'h00);
    wait_n(HOLD);
    read_chk("R5 target untouched", 15'h0400, 1'b1, 8'h00);
  endtask

  task automatic t_dip_restart;
    prot = 1; wait_n(4); prot = 0;
    wait_n(HOLD - 12);
    pgood = 0; wait_n(4); pgood = 1;    // dip late in the count
    wait_n(HOLD - 16);
    read_chk("R6 dip restarts count", 15'h0010, 1'b0, 8'h00);
    wait_n(20);
    read_chk("R6 unlock after full count", 15'h0010, 1'b1, 8'hA1);
  endtask

  task automatic t_batt;
    int c0 = wr_cnt;
    batt = 1;
    wait_n(4);
    write(15'h0500, 8'h42, 0, 1);
    chk("R7 no write in battery mode", wr_cnt, c0);
    read_chk("R7 no drive in battery mode", 15'h7FFF, 1'b0, 8'h00);
    batt = 0;
    wait_n(HOLD + 6);
    read_chk("R7 contents kept", 15'h7FFF, 1'b1, 8'h3C);
    read_chk("R7 no stray write", 15'h0500, 1'b1, 8'h00);
  endtask

  task automatic t_idle_needed;
    int c0 = wr_cnt;
    addr = 15'h0600; din = 8'hC3;
    prot = 1;
    wait_n(3);
    cs_n = 0; we_n = 0;                 // strobes low across protection
    wait_n(3);
    prot = 0;
    wait_n(HOLD + 8);
    we_n = 1;
    wait_n(3);
    cs_n = 1;
    wait_n(4);
    chk("R9 held strobes start nothing", wr_cnt, c0);
    write(15'h0600, 8'hC3, 0, 1);
    chk("R9 fresh cycle commits", wr_cnt, c0 + 1);
    read_chk("R9 data", 15'h0600, 1'b1, 8'hC3);
  endtask

  initial begin
    t_reset;
    t_write_orders;
    t_addr_abort;
    t_we_overrides;
    t_prot_discard;
    t_dip_restart;
    t_batt;
    t_idle_needed;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule